// File: doc/BRIEF.md
# Trimmable Nanosecond Time Counter

This block keeps a 64-bit time-of-day value in nanoseconds, clocked by a reference clock. On every reference cycle in which it runs, it adds a programmed step of one to eight nanoseconds. The step is chosen so that it matches the reference period.

The reference is never exactly at its nominal rate. To correct for this, the block supports a slow frequency trim. Every N-th running cycle, the step is changed by one nanosecond, either up or down, according to a direction bit. N is a 42-bit interval, and it equals the reference frequency divided by the wanted correction in parts per billion.

Software writes the block through a simple word-write port. Through that port it can:
- set the run controls,
- set the step,
- set the trim interval and direction,
- stage a 64-bit absolute time and then commit it.

A one-cycle snapshot request freezes the current count in a holding register, so that software can read it without a race.

Top module: `trim_ns_counter`

## Requirements
- R1: After reset the live count, the snapshot, the step, the trim interval and all control bits are zero.
- R2: The count advances only while control bit 0 (run) and control bit 5 (wide mode) are both set; otherwise it holds its value. Control is written at word address 0.
- R3: While running, each cycle adds step+1 ns, where step is the 3-bit value written at word address 4, bits [2:0].
- R4: Writing word address 3 with bit 0 set loads the time staged at addresses 1 (bits 31:0) and 2 (bits 63:32), on that same clock edge and in place of counting. Writing address 3 with bit 0 clear changes nothing.
- R5: The trim interval is 42 bits wide: bits 31:0 are written at address 5 and bits 41:32 at address 6, bits [9:0]. The upper 22 bits of the address-6 write are ignored.
- R6: With a nonzero interval N, every N-th running cycle adds step+2 ns when control bit 7 is clear, or step ns when control bit 7 is set.
- R7: An interval of zero disables trimming, so every running cycle adds step+1 ns.
- R8: A load restarts the trim interval, so the next trimmed cycle is the N-th running cycle after the load.
- R9: A snapshot request copies the count, as it stood before that edge, into the snapshot output on the same edge. The snapshot holds this value until the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Word address of the write |
| wr_data | input | 32 | Write data |
| snap_req | input | 1 | Snapshot request, one cycle |
| time_ns | output | 64 | Live nanosecond count |
| snap_ns | output | 64 | Last snapshot of the count |

## Verification
The bench keeps a cycle-by-cycle model of the count and compares it on every cycle. Because of this, a trim applied one cycle early or late, or in the wrong direction, shows up as a one-nanosecond drift that stays in every later comparison.

The corner cases the bench targets are these:
- An interval of one, which trims every cycle.
- An interval of zero, which a naive compare against N-1 would treat as trimming every cycle.
- A high interval word with its unused upper bits set. Without masking, these bits would make the interval enormous, and no trim would ever appear.
- A load in the middle of an interval. If the interval counter were not restarted, the first trim after the load would come early.
- A commit write with bit 0 clear, which must not load.
- Run enabled without wide mode, which must not count.

// File: rtl/tnc_pkg.sv
package tnc_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned CNT_W     = 64;
  localparam int unsigned STEP_W    = 3;
  localparam int unsigned TRIM_HI_W = 10;
  localparam int unsigned TRIM_W    = DATA_W + TRIM_HI_W;
  localparam int unsigned INC_W     = STEP_W + 1;

  typedef enum logic [2:0] {
    ADR_CTRL   = 3'd0,
    ADR_LD_LO  = 3'd1,
    ADR_LD_HI  = 3'd2,
    ADR_LD_GO  = 3'd3,
    ADR_STEP   = 3'd4,
    ADR_TRM_LO = 3'd5,
    ADR_TRM_HI = 3'd6
  } tnc_addr_e;

  localparam int unsigned CTRL_RUN_BIT  = 0;
  localparam int unsigned CTRL_WIDE_BIT = 5;
  localparam int unsigned CTRL_DIR_BIT  = 7;

  // nanoseconds added in one running cycle
  function automatic logic [INC_W-1:0] tnc_incr(input logic [STEP_W-1:0] step,
                                                input logic trim, input logic slow);
    logic [INC_W-1:0] base;
    base = {1'b0, step} + INC_W'(1);
    if (!trim)     return base;
    else if (slow) return base - INC_W'(1);
    else           return base + INC_W'(1);
  endfunction
endpackage

// File: rtl/tnc_regs.sv
module tnc_regs
  import tnc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              run,
  output logic              slow,
  output logic              load_now,
  output logic [CNT_W-1:0]  load_val,
  output logic [STEP_W-1:0] step,
  output logic [TRIM_W-1:0] interval
);
  logic [DATA_W-1:0]    ctrl_q, ld_lo_q, ld_hi_q, trm_lo_q;
  logic [TRIM_HI_W-1:0] trm_hi_q;
  logic [STEP_W-1:0]    step_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      ld_lo_q  <= '0;
      ld_hi_q  <= '0;
      trm_lo_q <= '0;
      trm_hi_q <= '0;
      step_q   <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADR_CTRL:   ctrl_q   <= wr_data;
        ADR_LD_LO:  ld_lo_q  <= wr_data;
        ADR_LD_HI:  ld_hi_q  <= wr_data;
        ADR_STEP:   step_q   <= wr_data[STEP_W-1:0];
        ADR_TRM_LO: trm_lo_q <= wr_data;
        ADR_TRM_HI: trm_hi_q <= wr_data[TRIM_HI_W-1:0];
        default: ;
      endcase
    end
  end

  assign run      = ctrl_q[CTRL_RUN_BIT] & ctrl_q[CTRL_WIDE_BIT];
  assign slow     = ctrl_q[CTRL_DIR_BIT];
  assign load_now = wr_en && (wr_addr == ADR_LD_GO) && wr_data[0];
  assign load_val = {ld_hi_q, ld_lo_q};
  assign step     = step_q;
  assign interval = {trm_hi_q, trm_lo_q};

  // R5: only ten bits of the high trim word are kept
  a_r5_trim_hi_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADR_TRM_HI) |=> interval[TRIM_W-1:DATA_W] == $past(wr_data[TRIM_HI_W-1:0]));
endmodule

// File: rtl/tnc_trim.sv
module tnc_trim
  import tnc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              restart,
  input  logic [TRIM_W-1:0] interval,
  output logic              fire
);
  logic [TRIM_W-1:0] cnt_q;
  logic              armed;

  assign armed = (interval != '0);
  assign fire  = run && !restart && armed && (cnt_q >= interval - TRIM_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (run)     cnt_q <= fire ? '0 : cnt_q + TRIM_W'(1);
  end

  // R7: zero interval never trims
  a_r7_zero_interval_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (interval == '0) |-> !fire);
  // R8: a load restarts the interval
  a_r8_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> cnt_q == '0);
  // R6: a trim begins a fresh interval
  a_r6_fire_rearms: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> cnt_q == '0);
endmodule

// File: rtl/tnc_accum.sv
module tnc_accum
  import tnc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              load_now,
  input  logic [CNT_W-1:0]  load_val,
  input  logic [STEP_W-1:0] step,
  input  logic              trim,
  input  logic              slow,
  input  logic              snap_req,
  output logic [CNT_W-1:0]  time_ns,
  output logic [CNT_W-1:0]  snap_ns
);
  logic [INC_W-1:0] inc;

  assign inc = tnc_incr(step, trim, slow);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        time_ns <= '0;
    else if (load_now) time_ns <= load_val;
    else if (run)      time_ns <= time_ns + {{(CNT_W-INC_W){1'b0}}, inc};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        snap_ns <= '0;
    else if (snap_req) snap_ns <= time_ns;
  end

  // R2: idle counter holds
  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load_now) |=> $stable(time_ns));
  // R4: load wins over counting
  a_r4_load_value: assert property (@(posedge clk) disable iff (!rst_n)
    load_now |=> time_ns == $past(load_val));
  // R3: untrimmed step
  a_r3_plain_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load_now && !trim) |=> time_ns == $past(time_ns) + CNT_W'($past(step)) + CNT_W'(1));
  // R9: snapshot captures pre-edge count
  a_r9_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
    snap_req |=> snap_ns == $past(time_ns));
endmodule

// File: rtl/trim_ns_counter.sv
module trim_ns_counter
  import tnc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              snap_req,
  output logic [CNT_W-1:0]  time_ns,
  output logic [CNT_W-1:0]  snap_ns
);
  logic              run, slow, load_now, trim_fire;
  logic [CNT_W-1:0]  load_val;
  logic [STEP_W-1:0] step;
  logic [TRIM_W-1:0] interval;

  tnc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .run(run), .slow(slow), .load_now(load_now), .load_val(load_val),
    .step(step), .interval(interval)
  );

  tnc_trim u_trim (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(load_now),
    .interval(interval), .fire(trim_fire)
  );

  tnc_accum u_accum (
    .clk(clk), .rst_n(rst_n), .run(run), .load_now(load_now), .load_val(load_val),
    .step(step), .trim(trim_fire), .slow(slow), .snap_req(snap_req),
    .time_ns(time_ns), .snap_ns(snap_ns)
  );

  // R6: a trim is only ever applied on a running cycle
  a_r6_trim_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    trim_fire |-> run);
endmodule

// File: tb/trim_ns_counter_tb.sv
module trim_ns_counter_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        snap_req = 1'b0;
  logic [63:0] time_ns, snap_ns;

  trim_ns_counter dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .snap_req(snap_req), .time_ns(time_ns), .snap_ns(snap_ns)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_checks = 0;
  int    n_fail   = 0;
  string cur_req  = "R1";
  bit    done     = 1'b0;

  // reference model state
  logic [31:0] m_ctrl, m_llo, m_lhi, m_tlo, m_thi;
  logic [2:0]  m_step;
  longint unsigned m_tcnt, m_time, m_snap;
  logic [63:0] q_time[$];
  logic [63:0] q_snap[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_llo = 0; m_lhi = 0; m_tlo = 0; m_thi = 0; m_step = 0;
      m_tcnt = 0; m_time = 0; m_snap = 0;
    end else begin
      longint unsigned n, inc;
      bit running, fire;
      running = m_ctrl[0] && m_ctrl[5];
      n = {22'd0, m_thi[9:0], m_tlo};
      if (snap_req) m_snap = m_time;
      if (wr_en && wr_addr == 3'd3 && wr_data[0]) begin
        m_time = {m_lhi, m_llo};
        m_tcnt = 0;
      end else if (running) begin
        fire = (n != 0) && (m_tcnt + 1 >= n);
        inc = 64'(m_step) + 1;
        if (fire) inc = m_ctrl[7] ? inc - 1 : inc + 1;
        m_time = m_time + inc;
        m_tcnt = fire ? 0 : m_tcnt + 1;
      end
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_ctrl = wr_data;
          3'd1: m_llo  = wr_data;
          3'd2: m_lhi  = wr_data;
          3'd4: m_step = wr_data[2:0];
          3'd5: m_tlo  = wr_data;
          3'd6: m_thi  = {22'd0, wr_data[9:0]};
          default: ;
        endcase
      end
    end
    q_time.push_back(m_time);
    q_snap.push_back(m_snap);
  end

  // monitor: compare away from the active edge
  always @(negedge clk) begin
    if (q_time.size() > 0 && rst_n) begin
      logic [63:0] et, es;
      et = q_time.pop_front();
      es = q_snap.pop_front();
      n_checks++;
      if (time_ns !== et) begin
        n_fail++;
        $display("FAIL %s time_ns actual=%0d expected=%0d", cur_req, time_ns, et);
      end
      n_checks++;
      if (snap_ns !== es) begin
        n_fail++;
        $display("FAIL %s snap_ns actual=%0d expected=%0d", cur_req, snap_ns, es);
      end
    end else begin
      q_time.delete();
      q_snap.delete();
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic snap();
    @(negedge clk);
    snap_req = 1'b1;
    @(negedge clk);
    snap_req = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired in %s", cur_req);
    finish_run();
  end

  initial begin
    idle(3);
    // R1: reset values at the ports
    n_checks++;
    if (time_ns !== 64'd0 || snap_ns !== 64'd0) begin
      n_fail++;
      $display("FAIL R1 reset actual=%0d/%0d expected=0/0", time_ns, snap_ns);
    end
    rst_n = 1'b1;
    idle(4);

    cur_req = "R2";              // run without wide mode: no counting
    wr(3'd0, 32'h1);
    idle(5);
    wr(3'd0, 32'h20);
    idle(5);

    cur_req = "R3";              // step 0 then 7
    wr(3'd0, 32'h21);
    idle(6);
    wr(3'd4, 32'hFFFF_FFF7);
    idle(6);
    snap();                      // R9 also observed here
    cur_req = "R9";
    idle(3);

    cur_req = "R4";              // load while running, then a non-load commit
    wr(3'd1, 32'hFFFF_FFF0);
    wr(3'd2, 32'h0000_0001);
    wr(3'd3, 32'h1);
    idle(4);
    wr(3'd3, 32'h0);
    idle(4);
    wr(3'd0, 32'h0);             // stopped: load still applies
    wr(3'd3, 32'h1);
    idle(3);
    wr(3'd0, 32'h21);

    cur_req = "R6";              // interval 4, faster then slower
    wr(3'd4, 32'h2);
    wr(3'd5, 32'd4);
    idle(12);
    wr(3'd0, 32'hA1);
    idle(12);
    wr(3'd5, 32'd1);             // trim every cycle
    idle(6);
    wr(3'd0, 32'h21);
    idle(6);

    cur_req = "R7";              // zero interval
    wr(3'd5, 32'd0);
    idle(10);

    cur_req = "R5";              // upper bits of high trim word ignored
    wr(3'd6, 32'hFFFF_FC00);
    wr(3'd5, 32'd3);
    idle(12);

    cur_req = "R8";              // load mid-interval restarts it
    wr(3'd5, 32'd5);
    idle(3);
    wr(3'd3, 32'h1);
    idle(12);
    wr(3'd1, 32'd100);
    wr(3'd3, 32'h1);
    idle(2);
    wr(3'd3, 32'h1);
    idle(8);

    cur_req = "R9";
    snap();
    idle(4);
    snap();
    idle(3);
    finish_run();
  end
endmodule